// File: doc/BRIEF.md
# Advanced Load Conflict Table

This block is a small associative table that lets a processor run a load earlier than stores that come before it in program order. When such a load issues speculatively, it allocates an entry holding its destination register tag and the 8-byte-aligned memory address it read. Every later store snoops the table. The store compares its aligned address against all live entries and removes each one that matches, because that load may have read a stale value.

Before the speculatively loaded register is used, a check operation names the register tag. A hit means no conflicting store arrived and the value may be used; the hit also frees the entry. A miss means the entry was killed, evicted, flushed or never existed, and the load has to be redone. An invalidate-all input drops every entry, for example on a pipeline flush. The table has a fixed number of entries. When it is full, a new allocation replaces the entry that was allocated longest ago.

Top module: `alct_table`

## Requirements
- R1: After reset the table holds no live entry, and `rsp_valid` and `rsp_hit` are 0.
- R2: A check for a tag that was allocated, and has not since been killed, freed, evicted or flushed, gives `rsp_valid`=1 and `rsp_hit`=1 in the cycle after the check.
- R3: A store invalidates an entry exactly when address bits [ADDR_W-1:3] of the store equal those of the load. A store in the same 8-byte block with a different offset kills the entry. A store to a different 8-byte block leaves it alive.
- R4: One store kills every live entry whose block matches, not only the first one.
- R5: A check for a tag with no live entry gives `rsp_valid`=1 and `rsp_hit`=0.
- R6: A check that hits frees the entry, so a second check of the same tag misses.
- R7: Allocating a tag that is already live overwrites that entry. The old address no longer matters, the new address does, and the entry counts as newly allocated.
- R8: When all entries are live and a new tag is allocated, the entry allocated longest ago is replaced, and its tag then misses. All other entries stay live.
- R9: When a store and a check meet the same entry in one cycle, the store acts first and the check misses.
- R10: `flush` empties the table. An allocation in the same cycle is not recorded, and a check in the same cycle misses.
- R11: An allocation takes effect after a same-cycle store or check. A matching store does not kill the new entry. A check of the same tag reports the old state and leaves the new entry live.
- R12: `rsp_valid` is 1 exactly in the cycle after a cycle with `chk_valid`=1, and `rsp_hit` is 0 whenever `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Allocate an entry for an advanced load |
| ld_tag | input | TAG_W (7) | Destination register tag of the load |
| ld_addr | input | ADDR_W (32) | Byte address read by the load |
| st_valid | input | 1 | A store is snooping the table |
| st_addr | input | ADDR_W (32) | Byte address written by the store |
| chk_valid | input | 1 | Check request |
| chk_tag | input | TAG_W (7) | Register tag being checked |
| flush | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Check response present (one cycle after request) |
| rsp_hit | output | 1 | Speculation succeeded; 0 means the load must be redone |

## Verification
The collision that matters most is a store and a check landing on the same entry in one cycle. The bench drives both in one clock, with a store address that falls in the checked load's 8-byte block at a different byte offset. It expects a miss on the following cycle. A control case uses a store to an unrelated block in the same cycle and expects a hit. The random phase keeps tags and addresses in small pools, so allocate, store, check and flush often overlap. Every response is compared with a reference model that applies the store before the check and the allocation last.

// File: rtl/alct_pkg.sv
package alct_pkg;

    localparam int ALCT_ENTRIES = 16;
    localparam int TAG_W        = 7;
    localparam int ADDR_W       = 32;
    localparam int GRAN_LOG2    = 3;

    localparam int LINE_W = ADDR_W - GRAN_LOG2;
    localparam int IDX_W  = (ALCT_ENTRIES > 1) ? $clog2(ALCT_ENTRIES) : 1;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [IDX_W-1:0]  idx_t;

    // one table slot
    typedef struct packed {
        logic  vld;
        tag_t  tag;
        line_t line;
    } slot_t;

    // how an allocation chooses its slot
    typedef enum logic [1:0] {
        PICK_SAME_TAG = 2'd0,
        PICK_FREE     = 2'd1,
        PICK_OLDEST   = 2'd2
    } pick_e;

    function automatic line_t addr_to_line(input addr_t a);
        return a[ADDR_W-1:GRAN_LOG2];
    endfunction

endpackage

// File: rtl/alct_prio_enc.sv
module alct_prio_enc #(
    parameter int N = 16,
    parameter int W = 4
) (
    input  logic [N-1:0] req,
    output logic [W-1:0] idx
);
    // lowest set index wins; zero when no request
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/alct_match.sv
module alct_match
    import alct_pkg::*;
#(
    parameter int N = ALCT_ENTRIES
) (
    input  slot_t [N-1:0] slots,
    input  tag_t          ld_tag,
    input  tag_t          chk_tag,
    input  line_t         st_line,
    output logic [N-1:0]  ld_tag_hit,
    output logic [N-1:0]  chk_tag_hit,
    output logic [N-1:0]  st_line_hit
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign ld_tag_hit[g]  = slots[g].vld && (slots[g].tag  == ld_tag);
        assign chk_tag_hit[g] = slots[g].vld && (slots[g].tag  == chk_tag);
        assign st_line_hit[g] = slots[g].vld && (slots[g].line == st_line);
    end
endmodule

// File: rtl/alct_age.sv
module alct_age #(
    parameter int N = 16,
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         touch,
    input  logic [W-1:0] touch_idx,
    output logic [W-1:0] oldest_idx
);
    // older_q[i][j] = 1 : slot i was allocated before slot j
    logic [N-1:0] older_q [N];
    logic [N-1:0] is_oldest;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) older_q[i] <= '0;
        end else if (touch) begin
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    if (W'(i) == touch_idx)      older_q[i][j] <= 1'b0;
                    else if (W'(j) == touch_idx) older_q[i][j] <= 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_old
        localparam logic [N-1:0] SELF = N'(1) << g;
        assign is_oldest[g] = &(older_q[g] | SELF);
    end

    alct_prio_enc #(.N(N), .W(W)) u_old_enc (
        .req (is_oldest),
        .idx (oldest_idx)
    );
endmodule

// File: rtl/alct_table.sv
module alct_table
    import alct_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              chk_valid,
    input  logic [TAG_W-1:0]  chk_tag,
    input  logic              flush,
    output logic              rsp_valid,
    output logic              rsp_hit
);
    localparam int N = ALCT_ENTRIES;

    slot_t [N-1:0] slot_q, slot_n;
    logic  [N-1:0] live_vec;
    logic  [N-1:0] ld_tag_hit, chk_tag_hit, st_line_hit;
    logic  [N-1:0] kill_vec, chk_live, chk_free;
    idx_t          same_idx, free_idx, oldest_idx, tgt_idx;
    pick_e         pick;
    logic          hit_n, touch;
    logic          rsp_valid_q, rsp_hit_q;

    for (genvar g = 0; g < N; g++) begin : g_live
        assign live_vec[g] = slot_q[g].vld;
    end

    alct_match #(.N(N)) u_match (
        .slots       (slot_q),
        .ld_tag      (ld_tag),
        .chk_tag     (chk_tag),
        .st_line     (addr_to_line(st_addr)),
        .ld_tag_hit  (ld_tag_hit),
        .chk_tag_hit (chk_tag_hit),
        .st_line_hit (st_line_hit)
    );

    alct_prio_enc #(.N(N), .W(IDX_W)) u_same_enc (
        .req (ld_tag_hit),
        .idx (same_idx)
    );

    alct_prio_enc #(.N(N), .W(IDX_W)) u_free_enc (
        .req (~live_vec),
        .idx (free_idx)
    );

    alct_age #(.N(N), .W(IDX_W)) u_age (
        .clk        (clk),
        .rst        (rst),
        .touch      (touch),
        .touch_idx  (tgt_idx),
        .oldest_idx (oldest_idx)
    );

    // store resolves first, then check, then allocation
    always_comb begin
        kill_vec = st_valid ? st_line_hit : '0;
        chk_live = chk_tag_hit & ~kill_vec;
        hit_n    = chk_valid && !flush && (|chk_live);
        chk_free = (chk_valid && !flush) ? chk_live : '0;

        if (|ld_tag_hit)      pick = PICK_SAME_TAG;
        else if (~&live_vec)  pick = PICK_FREE;
        else                  pick = PICK_OLDEST;

        unique case (pick)
            PICK_SAME_TAG: tgt_idx = same_idx;
            PICK_FREE:     tgt_idx = free_idx;
            default:       tgt_idx = oldest_idx;
        endcase

        touch  = ld_valid && !flush;
        slot_n = slot_q;
        for (int i = 0; i < N; i++) begin
            if (kill_vec[i] || chk_free[i] || flush) slot_n[i].vld = 1'b0;
        end
        if (touch) begin
            slot_n[tgt_idx].vld  = 1'b1;
            slot_n[tgt_idx].tag  = ld_tag;
            slot_n[tgt_idx].line = addr_to_line(ld_addr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q      <= '0;
            rsp_valid_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
        end else begin
            slot_q      <= slot_n;
            rsp_valid_q <= chk_valid;
            rsp_hit_q   <= hit_n;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_hit   = rsp_hit_q;
endmodule

// File: rtl/alct_checker.sv
module alct_checker
    import alct_pkg::*;
#(
    parameter int N = ALCT_ENTRIES
) (
    input logic          clk,
    input logic          rst,
    input logic          ld_valid,
    input logic          chk_valid,
    input logic          flush,
    input logic          rsp_valid,
    input logic          rsp_hit,
    input slot_t [N-1:0] slots
);
    logic [N-1:0] live;
    for (genvar g = 0; g < N; g++) begin : g_l
        assign live[g] = slots[g].vld;
    end

    // R12
    rsp_follows_chk: assert property (@(posedge clk) disable iff (rst)
        chk_valid |=> rsp_valid);

    // R12
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !chk_valid |=> !rsp_valid);

    // R5
    hit_needs_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid);

    // R10
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (live == '0));

    // R10
    flush_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (flush && chk_valid) |=> !rsp_hit);

    // R2
    alloc_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && !flush) |=> (live != '0));

    // R7
    always @(posedge clk) begin
        if (!rst) begin
            for (int i = 0; i < N; i++) begin
                for (int j = i + 1; j < N; j++) begin
                    uniq_tag_chk: assert (!(live[i] && live[j] &&
                        slots[i].tag == slots[j].tag))
                        else $error("duplicate live tag in slots %0d and %0d", i, j);
                end
            end
        end
    end
endmodule

bind alct_table alct_checker #(.N(alct_pkg::ALCT_ENTRIES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ld_valid  (ld_valid),
    .chk_valid (chk_valid),
    .flush     (flush),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .slots     (slot_q)
);

// File: tb/tb_alct_table.sv
`timescale 1ns/1ps
module tb_alct_table;
    import alct_pkg::*;

    localparam int NE = ALCT_ENTRIES;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ld_valid = 0, st_valid = 0, chk_valid = 0, flush = 0;
    logic [TAG_W-1:0]  ld_tag = '0, chk_tag = '0;
    logic [ADDR_W-1:0] ld_addr = '0, st_addr = '0;
    logic rsp_valid, rsp_hit;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    alct_table dut (
        .clk(clk), .rst(rst),
        .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr),
        .st_valid(st_valid), .st_addr(st_addr),
        .chk_valid(chk_valid), .chk_tag(chk_tag),
        .flush(flush),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit)
    );

    // reference model: stamps track allocation age
    bit      m_vld [NE];
    int      m_tag [NE];
    longint  m_blk [NE];
    longint  m_stamp [NE];
    longint  stamp_ctr = 0;

    function automatic void model_reset();
        for (int i = 0; i < NE; i++) m_vld[i] = 0;
        stamp_ctr = 0;
    endfunction

    function automatic bit model_step(bit lv, int lt, longint la, bit sv, longint sa,
                                      bit cv, int ct, bit fl);
        bit pre [NE];
        bit hit = 0;
        int tgt = -1;
        for (int i = 0; i < NE; i++) pre[i] = m_vld[i];
        for (int i = 0; i < NE; i++) begin
            if (pre[i] && cv && !fl && m_tag[i] == ct &&
                !(sv && m_blk[i] == (sa >> 3))) begin
                hit = 1;
                m_vld[i] = 0;
            end
            if (pre[i] && sv && m_blk[i] == (sa >> 3)) m_vld[i] = 0;
        end
        if (fl) begin
            for (int i = 0; i < NE; i++) m_vld[i] = 0;
        end else if (lv) begin
            for (int i = 0; i < NE; i++)
                if (pre[i] && m_tag[i] == lt) tgt = i;
            if (tgt < 0)
                for (int i = NE - 1; i >= 0; i--)
                    if (!pre[i]) tgt = i;
            if (tgt < 0) begin
                tgt = 0;
                for (int i = 1; i < NE; i++)
                    if (m_stamp[i] < m_stamp[tgt]) tgt = i;
            end
            m_vld[tgt] = 1; m_tag[tgt] = lt; m_blk[tgt] = la >> 3;
            m_stamp[tgt] = stamp_ctr; stamp_ctr++;
        end
        return hit;
    endfunction

    task automatic check(string req, bit act_v, bit act_h, bit exp_v, bit exp_h);
        total++;
        if (act_v !== exp_v || act_h !== exp_h) begin
            bad++;
            $display("FAIL %s: rsp_valid/rsp_hit got %0b/%0b expected %0b/%0b",
                     req, act_v, act_h, exp_v, exp_h);
        end
    endtask

    // drive one cycle at negedge, compare responses at the next negedge
    task automatic cyc(string req, bit lv, int lt, longint la, bit sv, longint sa,
                       bit cv, int ct, bit fl);
        bit eh;
        ld_valid = lv; ld_tag = TAG_W'(lt); ld_addr = ADDR_W'(la);
        st_valid = sv; st_addr = ADDR_W'(sa);
        chk_valid = cv; chk_tag = TAG_W'(ct); flush = fl;
        eh = model_step(lv, lt, la, sv, sa, cv, ct, fl);
        @(posedge clk);
        @(negedge clk);
        check(req, rsp_valid, rsp_hit, cv, eh);
    endtask

    task automatic ld(int t, longint a);   cyc("R2", 1, t, a, 0, 0, 0, 0, 0); endtask
    task automatic st(longint a);          cyc("R3", 0, 0, 0, 1, a, 0, 0, 0); endtask
    task automatic ck(string r, int t);    cyc(r, 0, 0, 0, 0, 0, 1, t, 0); endtask
    task automatic fl();                   cyc("R10", 0, 0, 0, 0, 0, 0, 0, 1); endtask

    initial begin
        #(5.0 * 200000);
        bad++; total++;
        $display("FAIL watchdog: run hung, got no end expected end");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1", rsp_valid, rsp_hit, 0, 0);
        ck("R1", 5);                       // empty table misses
        ck("R5", 99);
        // R2 / R6
        ld(3, 'h100); ck("R2", 3); ck("R6", 3);
        // R3 same block, other offset kills; other block does not
        ld(4, 'h200); st('h207); ck("R3", 4);
        ld(4, 'h200); st('h208); ck("R3", 4);
        // R4 one store kills several
        ld(10, 'h300); ld(11, 'h305); st('h304); ck("R4", 10); ck("R4", 11);
        // R7 overwrite
        ld(6, 'h400); ld(6, 'h500); st('h400); ck("R7", 6);
        ld(6, 'h400); ld(6, 'h500); st('h500); ck("R7", 6);
        // R8 eviction of oldest
        fl();
        for (int i = 0; i < NE; i++) ld(20 + i, 'h1000 + i * 8);
        ld(20, 'h2000);                    // re-allocated: now youngest
        ld(60, 'h3000);                    // evicts tag 21
        ck("R8", 21); ck("R8", 20); ck("R8", 22); ck("R8", 60);
        // R9 store and check together
        fl();
        ld(7, 'h600); cyc("R9", 0, 0, 0, 1, 'h601, 1, 7, 0);
        ld(7, 'h600); cyc("R9", 0, 0, 0, 1, 'h700, 1, 7, 0);
        // R10 flush with alloc and check
        ld(8, 'h800);
        cyc("R10", 1, 9, 'h900, 0, 0, 1, 8, 1);
        ck("R10", 9); ck("R10", 8);
        // R11 alloc vs same-cycle store and check
        cyc("R11", 1, 12, 'hA00, 1, 'hA00, 0, 0, 0); ck("R11", 12);
        ld(13, 'hB00);
        cyc("R11", 1, 13, 'hC00, 0, 0, 1, 13, 0);
        ck("R11", 13);
        // R12 quiet after idle
        cyc("R12", 0, 0, 0, 0, 0, 0, 0, 0);
        // random mix
        for (int n = 0; n < 4000; n++) begin
            bit lv = ($urandom % 3) == 0;
            bit sv = ($urandom % 3) == 0;
            bit cv = ($urandom % 2) == 0;
            bit f  = ($urandom % 97) == 0;
            int lt = $urandom % 24;
            int ct = $urandom % 24;
            longint la = longint'($urandom % 20) * 8 + ($urandom % 8);
            longint sa = longint'($urandom % 20) * 8 + ($urandom % 8);
            cyc("R2", lv, lt, la, sv, sa, cv, ct, f);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule